// File: doc/BRIEF.md
# Command-Mode Panel Bridge

This block connects a CPU register bus to one or two command-mode display panels that share a 16-bit parallel bus. The panel bus has a register-select line (low for command words, high for parameters and pixel data) and one chip select per panel. Software stores command words, parameter words and packed pixel pairs into the bridge's registers. It can also request a panel read, which places a 16-bit response in a receive buffer that software reads back later. Every panel access is one handshake on a ready/valid output port. While any panel access is still pending, the bridge holds off further CPU writes.

A pixel counter counts down the data and read accesses that remain in a frame. A start request marks the interface busy when a set of gating conditions holds. Busy drops when the counter runs out, and at that moment a sticky frame-done flag is raised on an interrupt output. The block also keeps a set of timing and format configuration words with fixed writable masks, so that software can read them back.

Top module: `cmdpanel_bridge`

## Requirements
- R1: After reset the control word reads 0x2, both interface configuration words read 0x00310000, the pixel counter reads 0, the frame-done flag reads 0 and the status word reads 0x001.
- R2: The control word (index 0) stores only bits 3:0. Bit 2 enables panel 0 (chip select bit 0) and bit 3 enables panel 1 (chip select bit 1). When both bits are set, a write goes to both panels in the same access.
- R3: A write to the command index (3) makes one panel access with the select line at 0, carrying bits 15:0. A write to the parameter index (4) makes one access with the select line at 1.
- R4: A write to the data index (5) makes two accesses with the select line at 1: bits 15:0 first, then bits 31:16. A stalled access keeps its outputs steady, and the CPU ready output stays low until every pending access has completed its handshake.
- R5: A write to index 6 reads the panel with the select line at 1, and a write to index 7 reads it with the select line at 0. Either read stores the panel response in the receive buffer, which both indices return. When both panels are enabled, only panel 0 is read.
- R6: Each data write, data read or status read lowers the pixel counter (index 2) by one. The counter holds at zero and never wraps. Busy clears when such an access leaves the counter at zero.
- R7: The status word (index 1) returns bit 0 = 1 and bit 8 = busy.
- R8: Writing the control word with bit 4 set starts a transfer, which sets busy, only under all of these conditions: the new bit 0 (enable) is 1, the new bit 1 (bypass) is 0, the display-mode input is 1, the block is not already busy, and the two configuration words do not share a set bit within bits 3:2.
- R9: The frame-done flag (index 8, bit 0, also on the interrupt output) is set when busy falls, or when a transfer is allowed to start while the counter is zero. Writing 1 to bit 0 of index 8 clears the flag.
- R10: Writable masks: configuration words (12, 13) 0x003F1FFF; on/off timing (14, 15) 0x3FFFFFFF; cycle timing (16, 17) 0x0FFFFFFF; data-cycle words (18 to 23) 0x0F1F0F1F; line skip (9) 0x7FF; sync widths (10, 11) 0xFFFF; pixel counter all 32 bits.
- R11: With neither panel enabled, command, parameter, data and read requests make no panel access and leave the receive buffer unchanged. The pixel counter still counts down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | CPU write request, taken when cpu_ready is high |
| cpu_addr | input | 5 | Register word index |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | High when a write can be taken |
| cpu_rdata | output | 32 | Read data for cpu_addr, combinational |
| disp_mode_en | input | 1 | Display controller has command-panel mode selected |
| frame_irq | output | 1 | Sticky frame-done flag |
| pnl_valid | output | 1 | Panel access pending |
| pnl_ready | input | 1 | Panel takes the access |
| pnl_cs | output | 2 | Chip selects, bit 0 for panel 0 |
| pnl_a0 | output | 1 | Register select: 0 command, 1 parameter or data |
| pnl_rd | output | 1 | Access is a read |
| pnl_wdata | output | 16 | Write half-word |
| pnl_rdata | input | 16 | Panel read response, sampled on the handshake |

## Verification
The bench checks the ordering of the two halves of a data write. A design that swaps them, or drops the select line on the second half, sends pixels in the wrong order. It drives the counter past zero; a wrapping counter would read 0xFFFFFFFF and hold busy high. It tries every start-blocking condition separately, including two configuration words that set different bits within 3:2 and so must not block. It holds the panel not-ready to confirm that a stalled access is neither lost nor duplicated. It also reads with both panels enabled, so that a design that does not favour panel 0 is exposed.

// File: rtl/cmdpanel_pkg.sv
// Shared register indices, masks and access kinds for the command-mode
// panel bridge. Assumes a 32-bit CPU word and a 16-bit panel bus.
package cmdpanel_pkg;
    localparam int AW      = 5;
    localparam int DW      = 32;
    localparam int HW      = 16;
    localparam int NPANEL  = 2;
    localparam int NCFG    = 2;
    localparam int NDCYC   = 6;

    localparam logic [AW-1:0] IX_CTRL   = 5'd0;
    localparam logic [AW-1:0] IX_STAT   = 5'd1;
    localparam logic [AW-1:0] IX_COUNT  = 5'd2;
    localparam logic [AW-1:0] IX_CMD    = 5'd3;
    localparam logic [AW-1:0] IX_PARAM  = 5'd4;
    localparam logic [AW-1:0] IX_DATA   = 5'd5;
    localparam logic [AW-1:0] IX_RDDAT  = 5'd6;
    localparam logic [AW-1:0] IX_RDSTA  = 5'd7;
    localparam logic [AW-1:0] IX_IRQ    = 5'd8;
    localparam logic [AW-1:0] IX_SKIP   = 5'd9;
    localparam logic [AW-1:0] IX_VSW    = 5'd10;
    localparam logic [AW-1:0] IX_HSW    = 5'd11;
    localparam logic [AW-1:0] IX_CFG0   = 5'd12;
    localparam logic [AW-1:0] IX_ONOFF0 = 5'd14;
    localparam logic [AW-1:0] IX_CYC0   = 5'd16;
    localparam logic [AW-1:0] IX_DCYC0  = 5'd18;

    localparam logic [DW-1:0] CFG_MASK   = 32'h003F_1FFF;
    localparam logic [DW-1:0] CFG_RESET  = 32'h0031_0000;
    localparam logic [DW-1:0] ONOFF_MASK = 32'h3FFF_FFFF;
    localparam logic [DW-1:0] CYC_MASK   = 32'h0FFF_FFFF;
    localparam logic [DW-1:0] DCYC_MASK  = 32'h0F1F_0F1F;
    localparam logic [DW-1:0] CFG_CLASH  = 32'h0000_000C;
    localparam int SKIP_W  = 11;
    localparam int SYNC_W  = 16;
    localparam int CTRL_W  = 4;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 4'h2;

    typedef enum logic [2:0] {
        ACC_NONE, ACC_CMD, ACC_PARAM, ACC_DATA, ACC_RD_DATA, ACC_RD_STAT
    } acc_kind_t;
endpackage

// File: rtl/cmdpanel_regs.sv
// Control and configuration storage. Holds the 4-bit control word and the
// masked timing/format words; returns them on a combinational read port.
// Assumes wr_en is high for one cycle per accepted CPU write.
module cmdpanel_regs
    import cmdpanel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic [AW-1:0]     rd_addr,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [DW-1:0]     cfg0_o,
    output logic [DW-1:0]     cfg1_o,
    output logic [DW-1:0]     rd_data_o,
    output logic              rd_hit_o
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [SKIP_W-1:0] skip_q;
    logic [SYNC_W-1:0] vsw_q, hsw_q;
    logic [DW-1:0]     cfg_q   [NCFG];
    logic [DW-1:0]     onoff_q [NCFG];
    logic [DW-1:0]     cyc_q   [NCFG];
    logic [DW-1:0]     dcyc_q  [NDCYC];

    // Store every writable word under its mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            skip_q <= '0;
            vsw_q  <= '0;
            hsw_q  <= '0;
            for (int i = 0; i < NCFG; i++) begin
                cfg_q[i]   <= CFG_RESET;
                onoff_q[i] <= '0;
                cyc_q[i]   <= '0;
            end
            for (int i = 0; i < NDCYC; i++) dcyc_q[i] <= '0;
        end else if (wr_en) begin
            if (addr == IX_CTRL) ctrl_q <= wdata[CTRL_W-1:0];
            if (addr == IX_SKIP) skip_q <= wdata[SKIP_W-1:0];
            if (addr == IX_VSW)  vsw_q  <= wdata[SYNC_W-1:0];
            if (addr == IX_HSW)  hsw_q  <= wdata[SYNC_W-1:0];
            for (int i = 0; i < NCFG; i++) begin
                if (int'(addr) == int'(IX_CFG0) + i)   cfg_q[i]   <= wdata & CFG_MASK;
                if (int'(addr) == int'(IX_ONOFF0) + i) onoff_q[i] <= wdata & ONOFF_MASK;
                if (int'(addr) == int'(IX_CYC0) + i)   cyc_q[i]   <= wdata & CYC_MASK;
            end
            for (int i = 0; i < NDCYC; i++)
                if (int'(addr) == int'(IX_DCYC0) + i) dcyc_q[i] <= wdata & DCYC_MASK;
        end
    end

    // Select the stored word that the read index names.
    always_comb begin
        rd_data_o = '0;
        rd_hit_o  = 1'b0;
        if (rd_addr == IX_CTRL) begin rd_data_o = DW'(ctrl_q); rd_hit_o = 1'b1; end
        if (rd_addr == IX_SKIP) begin rd_data_o = DW'(skip_q); rd_hit_o = 1'b1; end
        if (rd_addr == IX_VSW)  begin rd_data_o = DW'(vsw_q);  rd_hit_o = 1'b1; end
        if (rd_addr == IX_HSW)  begin rd_data_o = DW'(hsw_q);  rd_hit_o = 1'b1; end
        for (int i = 0; i < NCFG; i++) begin
            if (int'(rd_addr) == int'(IX_CFG0) + i)   begin rd_data_o = cfg_q[i];   rd_hit_o = 1'b1; end
            if (int'(rd_addr) == int'(IX_ONOFF0) + i) begin rd_data_o = onoff_q[i]; rd_hit_o = 1'b1; end
            if (int'(rd_addr) == int'(IX_CYC0) + i)   begin rd_data_o = cyc_q[i];   rd_hit_o = 1'b1; end
        end
        for (int i = 0; i < NDCYC; i++)
            if (int'(rd_addr) == int'(IX_DCYC0) + i) begin rd_data_o = dcyc_q[i]; rd_hit_o = 1'b1; end
    end

    assign ctrl_o = ctrl_q;
    assign cfg0_o = cfg_q[0];
    assign cfg1_o = cfg_q[1];

    AST_CFG_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[0] & ~CFG_MASK) == '0) else $error("cfg0 outside mask"); // R10
endmodule

// File: rtl/cmdpanel_seq.sv
// Panel access sequencer. Turns one request into one or two ready/valid
// panel accesses and captures read responses. Assumes req_valid is only
// raised while idle_o is high.
module cmdpanel_seq
    import cmdpanel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  acc_kind_t         req_kind,
    input  logic [DW-1:0]     req_word,
    input  logic [NPANEL-1:0] req_sel,
    output logic              idle_o,
    output logic [HW-1:0]     rxbuf_o,
    output logic              pnl_valid,
    input  logic              pnl_ready,
    output logic [NPANEL-1:0] pnl_cs,
    output logic              pnl_a0,
    output logic              pnl_rd,
    output logic [HW-1:0]     pnl_wdata,
    input  logic [HW-1:0]     pnl_rdata
);
    logic          hi_pend;
    logic [HW-1:0] hi_word;
    logic [NPANEL-1:0] rd_sel;

    // A read goes to the lowest enabled panel only.
    assign rd_sel = req_sel[0] ? NPANEL'(1) : NPANEL'(2);

    // Launch, hold and retire panel accesses; capture read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pnl_valid <= 1'b0;
            pnl_cs    <= '0;
            pnl_a0    <= 1'b0;
            pnl_rd    <= 1'b0;
            pnl_wdata <= '0;
            hi_pend   <= 1'b0;
            hi_word   <= '0;
            rxbuf_o   <= '0;
        end else if (pnl_valid) begin
            if (pnl_ready) begin
                if (pnl_rd) rxbuf_o <= pnl_rdata;
                if (hi_pend) begin
                    pnl_wdata <= hi_word;
                    hi_pend   <= 1'b0;
                end else begin
                    pnl_valid <= 1'b0;
                    pnl_rd    <= 1'b0;
                end
            end
        end else if (req_valid && req_sel != '0) begin
            pnl_valid <= 1'b1;
            pnl_wdata <= req_word[HW-1:0];
            pnl_cs    <= req_sel;
            pnl_rd    <= 1'b0;
            pnl_a0    <= 1'b1;
            case (req_kind)
                ACC_CMD:   pnl_a0 <= 1'b0;
                ACC_DATA:  begin hi_pend <= 1'b1; hi_word <= req_word[DW-1:HW]; end
                ACC_RD_DATA: begin pnl_rd <= 1'b1; pnl_cs <= rd_sel; end
                ACC_RD_STAT: begin pnl_rd <= 1'b1; pnl_cs <= rd_sel; pnl_a0 <= 1'b0; end
                default: ;
            endcase
        end
    end

    assign idle_o = !pnl_valid;

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        pnl_valid && !pnl_ready |=> pnl_valid && $stable(pnl_wdata) && $stable(pnl_a0) && $stable(pnl_cs))
        else $error("stalled access changed"); // R4
    AST_HIGH_HALF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        pnl_valid && pnl_ready && hi_pend |=> pnl_valid && pnl_a0 && !pnl_rd)
        else $error("second half missing"); // R4
    AST_READ_ONE_PANEL: assert property (@(posedge clk) disable iff (!rst_n)
        pnl_valid && pnl_rd |-> $countones(pnl_cs) == 1) else $error("read hit two panels"); // R5
    AST_ACCESS_HAS_PANEL: assert property (@(posedge clk) disable iff (!rst_n)
        pnl_valid |-> pnl_cs != '0) else $error("access with no panel"); // R11
endmodule

// File: rtl/cmdpanel_xfer.sv
// Frame transfer control: pixel counter, busy flag, start gating and the
// sticky frame-done flag. Assumes dec_i, cnt_wr_i, start_req_i and
// irq_clr_i are single-cycle strobes that never coincide.
module cmdpanel_xfer
    import cmdpanel_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic             start_req_i,
    input  logic             enable_i,
    input  logic             bypass_i,
    input  logic             mode_i,
    input  logic [DW-1:0]    cfg0_i,
    input  logic [DW-1:0]    cfg1_i,
    input  logic             irq_clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             busy_o,
    output logic             done_o
);
    logic start_ok, last_acc, clash;

    assign clash    = (cfg0_i & cfg1_i & CFG_CLASH) != '0;
    assign start_ok = start_req_i && enable_i && !bypass_i && mode_i && !busy_o && !clash;
    assign last_acc = busy_o && dec_i && cnt_o <= CNT_W'(1);

    // Pixel counter: load on write, count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_o <= '0;
        else if (cnt_wr_i)                cnt_o <= cnt_wdata_i;
        else if (dec_i && cnt_o != '0)    cnt_o <= cnt_o - CNT_W'(1);
    end

    // Busy: raised by an allowed start, dropped on the last access.
    always_ff @(posedge clk) begin
        if (!rst_n)                          busy_o <= 1'b0;
        else if (start_ok && cnt_o != '0)    busy_o <= 1'b1;
        else if (last_acc)                   busy_o <= 1'b0;
    end

    // Frame-done flag: set on completion, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      done_o <= 1'b0;
        else if ((start_ok && cnt_o == '0) || last_acc)  done_o <= 1'b1;
        else if (irq_clr_i)                              done_o <= 1'b0;
    end

    AST_COUNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i && !cnt_wr_i && cnt_o == '0 |=> cnt_o == '0) else $error("counter wrapped"); // R6
    AST_BUSY_ENDS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> cnt_o == '0) else $error("busy fell early"); // R6
    AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o) else $error("no frame done"); // R9
    AST_CLASH_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_req_i && clash && !busy_o |=> !busy_o) else $error("clash started"); // R8
endmodule

// File: rtl/cmdpanel_bridge.sv
// Top of the command-mode panel bridge. Decodes CPU writes into register
// updates, panel requests and transfer strobes, and builds the read word.
// Assumes a write is taken only in a cycle with cpu_ready high.
module cmdpanel_bridge
    import cmdpanel_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    output logic              cpu_ready,
    output logic [DW-1:0]     cpu_rdata,
    input  logic              disp_mode_en,
    output logic              frame_irq,
    output logic              pnl_valid,
    input  logic              pnl_ready,
    output logic [NPANEL-1:0] pnl_cs,
    output logic              pnl_a0,
    output logic              pnl_rd,
    output logic [HW-1:0]     pnl_wdata,
    input  logic [HW-1:0]     pnl_rdata
);
    logic              wr_acc, seq_idle, busy, done, reg_hit, counts;
    logic [CTRL_W-1:0] ctrl;
    logic [DW-1:0]     cfg0, cfg1, reg_rdata;
    logic [HW-1:0]     rxbuf;
    logic [CNT_W-1:0]  cnt;
    acc_kind_t         kind;

    assign wr_acc    = cpu_wr && seq_idle;
    assign cpu_ready = seq_idle;
    assign frame_irq = done;

    // Map the write index to a panel access kind.
    always_comb begin
        case (cpu_addr)
            IX_CMD:   kind = ACC_CMD;
            IX_PARAM: kind = ACC_PARAM;
            IX_DATA:  kind = ACC_DATA;
            IX_RDDAT: kind = ACC_RD_DATA;
            IX_RDSTA: kind = ACC_RD_STAT;
            default:  kind = ACC_NONE;
        endcase
    end

    assign counts = kind == ACC_DATA || kind == ACC_RD_DATA || kind == ACC_RD_STAT;

    cmdpanel_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_acc), .addr(cpu_addr), .wdata(cpu_wdata),
        .rd_addr(cpu_addr), .ctrl_o(ctrl), .cfg0_o(cfg0), .cfg1_o(cfg1),
        .rd_data_o(reg_rdata), .rd_hit_o(reg_hit)
    );

    cmdpanel_seq u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(wr_acc && kind != ACC_NONE),
        .req_kind(kind), .req_word(cpu_wdata), .req_sel(ctrl[3:2]),
        .idle_o(seq_idle), .rxbuf_o(rxbuf),
        .pnl_valid(pnl_valid), .pnl_ready(pnl_ready), .pnl_cs(pnl_cs),
        .pnl_a0(pnl_a0), .pnl_rd(pnl_rd), .pnl_wdata(pnl_wdata), .pnl_rdata(pnl_rdata)
    );

    cmdpanel_xfer #(.CNT_W(CNT_W)) u_xfer (
        .clk(clk), .rst_n(rst_n),
        .dec_i(wr_acc && counts),
        .cnt_wr_i(wr_acc && cpu_addr == IX_COUNT),
        .cnt_wdata_i(cpu_wdata[CNT_W-1:0]),
        .start_req_i(wr_acc && cpu_addr == IX_CTRL && cpu_wdata[4]),
        .enable_i(cpu_wdata[0]), .bypass_i(cpu_wdata[1]), .mode_i(disp_mode_en),
        .cfg0_i(cfg0), .cfg1_i(cfg1),
        .irq_clr_i(wr_acc && cpu_addr == IX_IRQ && cpu_wdata[0]),
        .cnt_o(cnt), .busy_o(busy), .done_o(done)
    );

    // Assemble the read word for the current index.
    always_comb begin
        case (cpu_addr)
            IX_STAT:  cpu_rdata = {23'b0, busy, 7'b0, 1'b1};
            IX_COUNT: cpu_rdata = DW'(cnt);
            IX_RDDAT, IX_RDSTA: cpu_rdata = DW'(rxbuf);
            IX_IRQ:   cpu_rdata = DW'(done);
            default:  cpu_rdata = reg_hit ? reg_rdata : '0;
        endcase
    end

    AST_CMD_REACHES_PANEL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc && cpu_addr == IX_CMD && ctrl[3:2] != '0 |=> pnl_valid && !pnl_a0 && !pnl_rd)
        else $error("command not launched"); // R3
    AST_NO_TAKE_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        pnl_valid |-> !cpu_ready) else $error("ready during access"); // R4
endmodule

// File: tb/test_cmdpanel_bridge.sv
`timescale 1ns/1ps
module test_cmdpanel_bridge;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cpu_wr = 1'b0, disp_mode_en = 1'b0, pnl_ready = 1'b1;
    logic [4:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0, cpu_rdata;
    logic        cpu_ready, frame_irq, pnl_valid, pnl_a0, pnl_rd;
    logic [1:0]  pnl_cs;
    logic [15:0] pnl_wdata, pnl_rdata;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;
    assign pnl_rdata = pnl_a0 ? 16'hD00D : 16'h5A7A;

    cmdpanel_bridge i_cmdpanel_bridge (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .disp_mode_en(disp_mode_en), .frame_irq(frame_irq), .pnl_valid(pnl_valid),
        .pnl_ready(pnl_ready), .pnl_cs(pnl_cs), .pnl_a0(pnl_a0), .pnl_rd(pnl_rd),
        .pnl_wdata(pnl_wdata), .pnl_rdata(pnl_rdata)
    );

    // Panel-side log, taken at the falling edge before each handshake edge.
    logic [15:0] lg_d [64];
    logic [1:0]  lg_cs [64];
    logic        lg_a0 [64], lg_rd [64];
    int lg_n = 0;
    always @(negedge clk) if (rst_n && pnl_valid && pnl_ready && lg_n < 64) begin
        lg_d[lg_n] = pnl_wdata; lg_cs[lg_n] = pnl_cs;
        lg_a0[lg_n] = pnl_a0; lg_rd[lg_n] = pnl_rd; lg_n = lg_n + 1;
    end

    typedef struct packed { logic [4:0] a; logic [31:0] w; logic [31:0] e; } vec_t;
    localparam vec_t VEC [13] = '{
        '{5'd12, 32'hFFFF_FFFF, 32'h003F_1FFF}, '{5'd13, 32'hFFFF_FFFF, 32'h003F_1FFF},
        '{5'd14, 32'hFFFF_FFFF, 32'h3FFF_FFFF}, '{5'd15, 32'hFFFF_FFFF, 32'h3FFF_FFFF},
        '{5'd16, 32'hFFFF_FFFF, 32'h0FFF_FFFF}, '{5'd17, 32'hFFFF_FFFF, 32'h0FFF_FFFF},
        '{5'd18, 32'hFFFF_FFFF, 32'h0F1F_0F1F}, '{5'd23, 32'hFFFF_FFFF, 32'h0F1F_0F1F},
        '{5'd9,  32'hFFFF_FFFF, 32'h0000_07FF}, '{5'd10, 32'hFFFF_FFFF, 32'h0000_FFFF},
        '{5'd11, 32'hFFFF_FFFF, 32'h0000_FFFF}, '{5'd0,  32'hFFFF_FFEF, 32'h0000_000F},
        '{5'd2,  32'h1234_5678, 32'h1234_5678}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        wait_idle();
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
        wait_idle();
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        cpu_addr = a; #1 d = cpu_rdata;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            report();
        end
    end

    initial begin
        logic [31:0] v;
        int base;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state
        rd(5'd0, v);  check("R1 ctrl reset", v, 32'h2);
        rd(5'd12, v); check("R1 cfg0 reset", v, 32'h0031_0000);
        rd(5'd13, v); check("R1 cfg1 reset", v, 32'h0031_0000);
        rd(5'd2, v);  check("R1 count reset", v, 32'h0);
        rd(5'd8, v);  check("R1 done reset", v, 32'h0);
        rd(5'd1, v);  check("R1 R7 status reset", v, 32'h1);

        // Mask table walk
        foreach (VEC[i]) begin
            wr(VEC[i].a, VEC[i].w);
            rd(VEC[i].a, v);
            check($sformatf("R10 R2 mask idx %0d", VEC[i].a), v, VEC[i].e);
        end

        // Command and parameter words, panel 0
        wr(5'd0, 32'h4);
        base = lg_n;
        wr(5'd3, 32'hABCD_1234);
        check("R3 cmd count", lg_n - base, 1);
        check("R3 cmd word", {lg_cs[base], lg_a0[base], lg_rd[base], lg_d[base]}, {2'b01, 1'b0, 1'b0, 16'h1234});
        wr(5'd4, 32'h0000_9876);
        check("R3 param word", {lg_cs[base+1], lg_a0[base+1], lg_d[base+1]}, {2'b01, 1'b1, 16'h9876});

        // Both panels on a write
        wr(5'd0, 32'hC);
        base = lg_n;
        wr(5'd3, 32'h55);
        check("R2 both panels", {lg_cs[base], lg_d[base]}, {2'b11, 16'h0055});

        // Data write: low half then high half
        wr(5'd2, 32'd3);
        base = lg_n;
        wr(5'd5, 32'hBEEF_CAFE);
        check("R4 data count", lg_n - base, 2);
        check("R4 low first", {lg_a0[base], lg_d[base]}, {1'b1, 16'hCAFE});
        check("R4 high second", {lg_a0[base+1], lg_d[base+1]}, {1'b1, 16'hBEEF});
        rd(5'd2, v); check("R6 count after data", v, 32'd2);

        // Reads: both enabled goes to panel 0 only
        base = lg_n;
        wr(5'd6, 32'h0);
        check("R5 data read", {lg_cs[base], lg_a0[base], lg_rd[base]}, {2'b01, 1'b1, 1'b1});
        rd(5'd6, v); check("R5 rx data", v, 32'h0000_D00D);
        wr(5'd0, 32'h8);
        base = lg_n;
        wr(5'd7, 32'h0);
        check("R5 status read", {lg_cs[base], lg_a0[base], lg_rd[base]}, {2'b10, 1'b0, 1'b1});
        rd(5'd7, v); check("R5 rx status", v, 32'h0000_5A7A);
        rd(5'd2, v); check("R6 count to zero", v, 32'd0);
        wr(5'd7, 32'h0);
        rd(5'd2, v); check("R6 count saturates", v, 32'd0);

        // No panel enabled
        wr(5'd0, 32'h0);
        wr(5'd2, 32'd5);
        base = lg_n;
        wr(5'd3, 32'h77);
        wr(5'd6, 32'h0);
        check("R11 no access", lg_n - base, 0);
        rd(5'd6, v); check("R11 rx kept", v, 32'h0000_5A7A);
        rd(5'd2, v); check("R11 count moves", v, 32'd4);

        // Start gating
        wr(5'd12, 32'h0); wr(5'd13, 32'h0);
        wr(5'd2, 32'd2);
        disp_mode_en = 1'b0;
        wr(5'd0, 32'h15); rd(5'd1, v); check("R8 mode off blocks", v, 32'h1);
        disp_mode_en = 1'b1;
        wr(5'd0, 32'h17); rd(5'd1, v); check("R8 bypass blocks", v, 32'h1);
        wr(5'd0, 32'h14); rd(5'd1, v); check("R8 disabled blocks", v, 32'h1);
        wr(5'd12, 32'h4); wr(5'd13, 32'h4);
        wr(5'd0, 32'h15); rd(5'd1, v); check("R8 clash blocks", v, 32'h1);
        wr(5'd13, 32'h8);
        wr(5'd0, 32'h15); rd(5'd1, v); check("R8 R7 start busy", v, 32'h101);
        rd(5'd8, v); check("R9 no done yet", v, 32'h0);
        wr(5'd5, 32'h1111_2222);
        rd(5'd1, v); check("R6 still busy", v, 32'h101);
        wr(5'd5, 32'h3333_4444);
        rd(5'd1, v); check("R6 busy cleared", v, 32'h1);
        rd(5'd8, v); check("R9 done set", v, 32'h1);
        check("R9 irq pin", frame_irq, 1'b1);
        wr(5'd8, 32'h1);
        rd(5'd8, v); check("R9 done cleared", v, 32'h0);
        wr(5'd0, 32'h15);
        rd(5'd8, v); check("R9 zero-count start", v, 32'h1);
        rd(5'd1, v); check("R9 zero-count idle", v, 32'h1);

        // Stalled panel
        wr(5'd0, 32'h4);
        @(posedge clk); #1 pnl_ready = 1'b0;
        base = lg_n;
        @(negedge clk); cpu_wr = 1'b1; cpu_addr = 5'd3; cpu_wdata = 32'h0000_1111;
        @(negedge clk); cpu_wr = 1'b0;
        repeat (5) @(negedge clk);
        check("R4 stall holds", {cpu_ready, pnl_valid, pnl_wdata}, {1'b0, 1'b1, 16'h1111});
        @(posedge clk); #1 pnl_ready = 1'b1;
        wait_idle();
        check("R4 stall once", lg_n - base, 1);

        finished = 1;
        report();
    end
endmodule